// File: doc/BRIEF.md
# Two-Wire Slave Control Register Bank

This block is a slave on a two-wire serial control bus (I2C). It holds a bank of 23 byte-wide control registers, addressed 00h through 16h, and gives a bus master byte access to them. Both bus lines are oversampled by the system clock. Each line passes through a two-flop synchronizer before any edge is detected. The slave answers to one fixed 7-bit device address, 63h. It pulls SDA low through an open-drain enable output; it never drives SDA high.

A write transfer begins with the device address and R/W=0. The next byte sets an internal register pointer. Each byte after that is stored at the pointer, and the pointer then advances. A read transfer returns bytes from the pointer, which advances after each byte. A read that follows a repeated START, directly after a pointer write, therefore returns data from the register just selected. The pointer never moves past 16h: once there, further bytes keep landing on, or coming from, 16h. The whole register image is presented as one flat level output to the surrounding logic. It carries no handshake and is always valid.

Top module: `i2c_regbank_top`

## Requirements
- R1: A byte of 1100011 followed by an R/W bit (C6h for write, C7h for read) is acknowledged by holding SDA low during the ninth SCL clock. The slave samples SDA on rising SCL, MSB first.
- R2: An address byte that does not match gets no acknowledge. The slave then keeps SDA released and changes no register until the next START.
- R3: In a write transfer, the first byte after the address loads the register pointer. A value above 16h loads 16h. The byte is acknowledged.
- R4: Each later byte of a write transfer is acknowledged and stored in the register at the pointer, and the pointer then advances by one. Register contents change only through such bytes.
- R5: The pointer never exceeds 16h. Write or read bytes that reach 16h leave the pointer at 16h, so later bytes keep accessing 16h.
- R6: In a read transfer, the slave sends the register at the pointer MSB first. It changes its SDA bit only after SCL falls, and the pointer advances after each byte sent.
- R7: A read that has no pointer byte before it starts at the current pointer. That is the value left by the last pointer byte, write byte or read byte.
- R8: A repeated START followed by C7h reads from the pointer just written. A repeated START followed by C6h begins a new write transfer, whose first byte reloads the pointer.
- R9: A master NACK after a read byte ends the transmission. The slave keeps SDA released for any further clocks until a START or STOP.
- R10: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. A START cuts short a byte in progress without storing it. After a STOP, bytes without a START are ignored.
- R11: Reset clears all registers to 00h, sets the pointer to 00h and releases SDA.
- R12: The SDA enable changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, which oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | High pulls SDA low; low releases it |
| reg_q | output | 184 | Register image; register n sits at bits n*8+7 down to n*8 |

## Verification
The bench goes after the top of the pointer range with four write bytes from 14h. A pointer that wrapped to 00h or ran past 16h would spread those bytes into the wrong registers. It also reads 16h three times, which would return stale or zero data if the read side did not saturate. A pointer byte of 3Fh must be clamped, or the next write would land outside the bank. A repeated START is issued in the middle of a data byte; a design that committed partial shift data there would corrupt a register, and a per-clock comparison of the whole register image catches it. Three more cases are covered. After a master NACK the bench keeps clocking: a slave that failed to release SDA would show as zero bits. A wrong device address is followed by data bytes, and a slave that failed to ignore them would acknowledge them. Bytes sent after a STOP would be acknowledged by a slave that had not returned to idle.

// File: rtl/i2c_rb_pkg.sv
package i2c_rb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK,
    ST_SKIP
  } rb_state_e;

  localparam int BUS_BYTE = 8;
endpackage

// File: rtl/i2c_rb_sync.sv
module i2c_rb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_p,
  output logic stop_p
);
  localparam int NLINE = 2;

  logic [NLINE-1:0] line_in;
  logic [NLINE-1:0] line_s;
  logic [NLINE-1:0] line_d;

  assign line_in = {sda_i, scl_i};

  for (genvar l = 0; l < NLINE; l++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain     <= '1;
        line_d[l] <= 1'b1;
      end else begin
        chain     <= {chain[STAGES-2:0], line_in[l]};
        line_d[l] <= chain[STAGES-1];
      end
    end
    assign line_s[l] = chain[STAGES-1];
  end

  logic scl_now, scl_old, sda_now, sda_old;
  assign scl_now = line_s[0];
  assign scl_old = line_d[0];
  assign sda_now = line_s[1];
  assign sda_old = line_d[1];

  assign sda_s    = sda_now;
  assign scl_rise = scl_now & ~scl_old;
  assign scl_fall = ~scl_now & scl_old;
  assign start_p  = scl_now & scl_old & sda_old & ~sda_now;
  assign stop_p   = scl_now & scl_old & ~sda_old & sda_now;
endmodule

// File: rtl/i2c_rb_regs.sv
module i2c_rb_regs #(
  parameter int NREG = 23,
  parameter int DW   = 8,
  parameter int AW   = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [AW-1:0]        wr_addr,
  input  logic [DW-1:0]        wr_data,
  input  logic [AW-1:0]        rd_addr,
  output logic [DW-1:0]        rd_data,
  output logic [NREG*DW-1:0]   regs_flat
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [DW-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        q <= '0;
      else if (wr_en && wr_addr == AW'(g))
        q <= wr_data;
    end
    assign regs_flat[g*DW +: DW] = q;
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NREG; i++) begin
      if (rd_addr == AW'(i))
        rd_data = regs_flat[i*DW +: DW];
    end
  end
endmodule

// File: rtl/i2c_rb_fsm.sv
module i2c_rb_fsm
  import i2c_rb_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h63,
  parameter int         NREG     = 23,
  parameter int         DW       = 8,
  parameter int         AW       = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_p,
  input  logic          stop_p,
  input  logic          sda_s,
  input  logic [DW-1:0] rd_data,
  output logic          sda_oe,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic [AW-1:0] ptr,
  output logic          skipping
);
  localparam logic [AW-1:0] TOP   = AW'(NREG - 1);
  localparam int            CNT_W = $clog2(BUS_BYTE + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BUS_BYTE);

  rb_state_e            state;
  logic [CNT_W-1:0]     cnt;
  logic [BUS_BYTE-1:0]  shreg;
  logic                 is_rd;
  logic                 want_ptr;
  logic                 nack_q;

  function automatic logic [AW-1:0] sat_inc(input logic [AW-1:0] p);
    return (p == TOP) ? TOP : p + AW'(1);
  endfunction

  function automatic logic [AW-1:0] clamp(input logic [BUS_BYTE-1:0] b);
    return (int'(b) > NREG - 1) ? TOP : AW'(b);
  endfunction

  assign skipping = (state == ST_SKIP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      shreg    <= '0;
      is_rd    <= 1'b0;
      want_ptr <= 1'b0;
      nack_q   <= 1'b0;
      sda_oe   <= 1'b0;
      wr_en    <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
      ptr      <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_p) begin
        state  <= ST_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (stop_p) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        unique case (state)
          ST_ADDR: begin
            if (scl_rise) begin
              shreg <= {shreg[BUS_BYTE-2:0], sda_s};
              cnt   <= cnt + CNT_W'(1);
            end else if (scl_fall && cnt == FULL) begin
              if (shreg[BUS_BYTE-1:1] == DEV_ADDR) begin
                state    <= ST_ADDR_ACK;
                sda_oe   <= 1'b1;
                is_rd    <= shreg[0];
                want_ptr <= ~shreg[0];
              end else begin
                state <= ST_SKIP;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall) begin
              cnt <= '0;
              if (is_rd) begin
                state  <= ST_RD;
                shreg  <= rd_data;
                sda_oe <= ~rd_data[DW-1];
              end else begin
                state  <= ST_WR;
                sda_oe <= 1'b0;
              end
            end
          end
          ST_WR: begin
            if (scl_rise) begin
              shreg <= {shreg[BUS_BYTE-2:0], sda_s};
              cnt   <= cnt + CNT_W'(1);
            end else if (scl_fall && cnt == FULL) begin
              state  <= ST_WR_ACK;
              sda_oe <= 1'b1;
              if (want_ptr) begin
                ptr      <= clamp(shreg);
                want_ptr <= 1'b0;
              end else begin
                wr_en   <= 1'b1;
                wr_addr <= ptr;
                wr_data <= shreg;
                ptr     <= sat_inc(ptr);
              end
            end
          end
          ST_WR_ACK: begin
            if (scl_fall) begin
              state  <= ST_WR;
              cnt    <= '0;
              sda_oe <= 1'b0;
            end
          end
          ST_RD: begin
            if (scl_rise) begin
              cnt <= cnt + CNT_W'(1);
            end else if (scl_fall) begin
              if (cnt == FULL) begin
                state  <= ST_RD_ACK;
                sda_oe <= 1'b0;
                ptr    <= sat_inc(ptr);
              end else begin
                shreg  <= {shreg[BUS_BYTE-2:0], 1'b0};
                sda_oe <= ~shreg[BUS_BYTE-2];
              end
            end
          end
          ST_RD_ACK: begin
            if (scl_rise) begin
              nack_q <= sda_s;
            end else if (scl_fall) begin
              if (nack_q) begin
                state <= ST_SKIP;
              end else begin
                state  <= ST_RD;
                cnt    <= '0;
                shreg  <= rd_data;
                sda_oe <= ~rd_data[DW-1];
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_regbank_top.sv
module i2c_regbank_top #(
  parameter logic [6:0] DEV_ADDR    = 7'h63,
  parameter int         NREG        = 23,
  parameter int         DW          = 8,
  parameter int         SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe,
  output logic [NREG*DW-1:0] reg_q
);
  localparam int AW = $clog2(NREG);

  logic          sda_s, scl_rise, scl_fall, start_p, stop_p;
  logic          wr_en, skipping;
  logic [AW-1:0] wr_addr, ptr;
  logic [DW-1:0] wr_data, rd_data;

  i2c_rb_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_p  (start_p),
    .stop_p   (stop_p)
  );

  i2c_rb_fsm #(.DEV_ADDR(DEV_ADDR), .NREG(NREG), .DW(DW), .AW(AW)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_p  (start_p),
    .stop_p   (stop_p),
    .sda_s    (sda_s),
    .rd_data  (rd_data),
    .sda_oe   (sda_oe),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .ptr      (ptr),
    .skipping (skipping)
  );

  i2c_rb_regs #(.NREG(NREG), .DW(DW), .AW(AW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_addr   (ptr),
    .rd_data   (rd_data),
    .regs_flat (reg_q)
  );
endmodule

// File: rtl/i2c_regbank_chk.sv
module i2c_regbank_chk #(
  parameter int NREG = 23,
  parameter int DW   = 8,
  parameter int AW   = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               scl_i,
  input logic               sda_oe,
  input logic [NREG*DW-1:0] reg_q,
  input logic               wr_en,
  input logic [AW-1:0]      ptr,
  input logic               skipping
);
  p_reset_clear_r11: assert property (@(posedge clk)
    $rose(rst_n) |-> (reg_q == '0 && !sda_oe && ptr == '0));

  p_skip_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
    skipping |-> !sda_oe);

  p_ptr_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ptr <= AW'(NREG - 1));

  p_write_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(reg_q));

  p_oe_scl_low_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_i);
endmodule

bind i2c_regbank_top i2c_regbank_chk #(.NREG(NREG), .DW(DW), .AW(AW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .scl_i    (scl_i),
  .sda_oe   (sda_oe),
  .reg_q    (reg_q),
  .wr_en    (wr_en),
  .ptr      (ptr),
  .skipping (skipping)
);

// File: tb/tb_i2c_regbank_top.sv
module tb_i2c_regbank_top;
  localparam int CLK_PERIOD = 10;
  localparam int Q          = 6;
  localparam int NREG       = 23;
  localparam int TOPA       = NREG - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic sda_line;
  logic [NREG*8-1:0] reg_q;

  int n_chk = 0;
  int n_fail = 0;
  int model_regs [NREG];
  int model_ptr = 0;
  bit cmp_en = 1'b0;
  bit oe_prev = 1'b0;
  bit scl_prev = 1'b1;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign sda_line = sda_m & ~sda_oe;

  i2c_regbank_top dut (
    .clk    (clk),
    .rst_n  (rst_n),
    .scl_i  (scl_m),
    .sda_i  (sda_line),
    .sda_oe (sda_oe),
    .reg_q  (reg_q)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int sat(input int p);
    return (p >= TOPA) ? TOPA : p + 1;
  endfunction

  // reference image compared every clock while no write is in flight (R4 R10 R2)
  always @(negedge clk) begin
    #1;
    if (rst_n && cmp_en) begin
      for (int i = 0; i < NREG; i++) begin
        if (reg_q[i*8 +: 8] !== model_regs[i][7:0])
          check(1'b0, $sformatf("R4 reg %0h image", i), int'(reg_q[i*8 +: 8]), model_regs[i]);
      end
      n_chk++;
    end
    // R12: enable may change only while SCL is low, judged against the previous sample
    if (rst_n && sda_oe !== oe_prev)
      check(!scl_prev && !scl_m, "R12 sda_oe change with SCL high", int'(scl_m), 0);
    oe_prev  = sda_oe;
    scl_prev = scl_m;
  end

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; scl_m = 1'b1; wq();
    sda_m = 1'b0; wq();
    scl_m = 1'b0; wq();
  endtask

  task automatic bus_rstart();
    sda_m = 1'b1; wq();
    scl_m = 1'b1; wq();
    sda_m = 1'b0; wq();
    scl_m = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq();
    scl_m = 1'b1; wq();
    sda_m = 1'b1; wq();
  endtask

  task automatic clk_bit(input bit b, output bit s);
    sda_m = b; wq();
    scl_m = 1'b1; wq();
    s = sda_line; wq();
    scl_m = 1'b0; wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    bit s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
    clk_bit(1'b1, s);
    ack = !s;
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] d);
    bit s;
    d = '0;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, s);
      d = {d[6:0], s};
    end
    clk_bit(!mack, s);
  endtask

  task automatic addr_byte(input logic [7:0] b, input bit exp_ack, input string tag);
    bit a;
    send_byte(b, a);
    check(a == exp_ack, tag, int'(a), int'(exp_ack));
  endtask

  task automatic ptr_byte(input logic [7:0] b, input string tag);
    bit a;
    send_byte(b, a);
    check(a, tag, int'(a), 1);
    model_ptr = (int'(b) > TOPA) ? TOPA : int'(b);
  endtask

  task automatic data_byte(input logic [7:0] b, input string tag);
    bit a;
    cmp_en = 1'b0;
    send_byte(b, a);
    check(a, tag, int'(a), 1);
    model_regs[model_ptr] = int'(b);
    model_ptr = sat(model_ptr);
    cmp_en = 1'b1;
  endtask

  task automatic read_exp(input bit mack, input string tag);
    logic [7:0] d;
    recv_byte(mack, d);
    check(int'(d) == model_regs[model_ptr], tag, int'(d), model_regs[model_ptr]);
    model_ptr = sat(model_ptr);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] d;
    bit a;
    for (int i = 0; i < NREG; i++) model_regs[i] = 0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(reg_q == '0, "R11 registers cleared", int'(reg_q[31:0]), 0);
    check(sda_oe == 1'b0, "R11 SDA released", int'(sda_oe), 0);
    cmp_en = 1'b1;

    // plain write from 05h
    bus_start();
    addr_byte(8'hC6, 1'b1, "R1 write address ack");
    ptr_byte(8'h05, "R3 pointer byte ack");
    data_byte(8'h11, "R4 data ack");
    data_byte(8'h22, "R4 data ack");
    data_byte(8'h33, "R4 data ack");
    bus_stop();
    check(reg_q[5*8 +: 8] == 8'h11, "R4 reg05", int'(reg_q[5*8 +: 8]), 'h11);

    // pointer only, then a plain read continues from it
    bus_start();
    addr_byte(8'hC6, 1'b1, "R1 write address ack");
    ptr_byte(8'h06, "R3 pointer only");
    bus_stop();
    bus_start();
    addr_byte(8'hC7, 1'b1, "R1 read address ack");
    read_exp(1'b1, "R7 plain read first byte");
    read_exp(1'b0, "R6 read increments");
    bus_stop();

    // combined transfer: pointer, repeated START, read; then clocks after NACK
    bus_start();
    addr_byte(8'hC6, 1'b1, "R1 write address ack");
    ptr_byte(8'h05, "R8 pointer before Sr");
    bus_rstart();
    addr_byte(8'hC7, 1'b1, "R8 read after Sr ack");
    read_exp(1'b1, "R8 combined read 05h");
    read_exp(1'b1, "R6 combined read 06h");
    read_exp(1'b0, "R6 combined read 07h");
    recv_byte(1'b1, d);
    check(d == 8'hFF, "R9 SDA released after NACK", int'(d), 'hFF);
    bus_stop();

    // saturation at the top register
    bus_start();
    addr_byte(8'hC6, 1'b1, "R1 write address ack");
    ptr_byte(8'h14, "R3 pointer near top");
    data_byte(8'hAA, "R5 write 14h");
    data_byte(8'hBB, "R5 write 15h");
    data_byte(8'hCC, "R5 write 16h");
    data_byte(8'hDD, "R5 write stays 16h");
    bus_stop();
    check(reg_q[22*8 +: 8] == 8'hDD, "R5 reg16 overwritten", int'(reg_q[22*8 +: 8]), 'hDD);
    check(reg_q[0 +: 8] == 8'h00, "R5 no wrap to 00h", int'(reg_q[0 +: 8]), 0);
    bus_start();
    addr_byte(8'hC7, 1'b1, "R1 read address ack");
    read_exp(1'b1, "R5 read 16h");
    read_exp(1'b1, "R5 read 16h again");
    read_exp(1'b0, "R5 read 16h third");
    bus_stop();

    // pointer above top is clamped
    bus_start();
    addr_byte(8'hC6, 1'b1, "R1 write address ack");
    ptr_byte(8'h3F, "R3 pointer 3Fh");
    data_byte(8'h77, "R3 clamped write");
    bus_stop();
    check(reg_q[22*8 +: 8] == 8'h77, "R3 clamp to 16h", int'(reg_q[22*8 +: 8]), 'h77);

    // wrong device address: nothing acknowledged, nothing written
    bus_start();
    addr_byte(8'hA6, 1'b0, "R2 foreign address nack");
    addr_byte(8'h02, 1'b0, "R2 ignored byte nack");
    addr_byte(8'h99, 1'b0, "R2 ignored byte nack");
    bus_stop();
    check(reg_q[2*8 +: 8] == 8'h00, "R2 reg02 untouched", int'(reg_q[2*8 +: 8]), 0);

    // repeated START with a write address reloads the pointer
    bus_start();
    addr_byte(8'hC6, 1'b1, "R1 write address ack");
    ptr_byte(8'h02, "R8 first pointer");
    bus_rstart();
    addr_byte(8'hC6, 1'b1, "R8 write after Sr ack");
    ptr_byte(8'h09, "R8 pointer reloaded");
    data_byte(8'h5C, "R8 data after reload");
    bus_stop();
    check(reg_q[9*8 +: 8] == 8'h5C, "R8 reg09", int'(reg_q[9*8 +: 8]), 'h5C);
    check(reg_q[2*8 +: 8] == 8'h00, "R8 reg02 untouched", int'(reg_q[2*8 +: 8]), 0);

    // START in the middle of a data byte aborts it
    bus_start();
    addr_byte(8'hC6, 1'b1, "R1 write address ack");
    ptr_byte(8'h01, "R10 pointer 01h");
    for (int i = 0; i < 4; i++) clk_bit(1'b1, a);
    bus_rstart();
    addr_byte(8'hC6, 1'b1, "R10 address after abort");
    bus_stop();
    check(reg_q[1*8 +: 8] == 8'h00, "R10 aborted byte not stored", int'(reg_q[1*8 +: 8]), 0);
    bus_start();
    addr_byte(8'hC7, 1'b1, "R1 read address ack");
    read_exp(1'b0, "R10 pointer kept across abort");
    bus_stop();

    // after STOP, a byte with no START is ignored
    addr_byte(8'hC6, 1'b0, "R10 no ack without START");
    bus_stop();

    repeat (4) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule